// File: doc/BRIEF.md
# Sleep and LED Pulse Controller

This block holds the sleep state of a powered device in a power-over-Ethernet system. It watches three active-low control pins: a sleep request, a wake request and a low-power select. It also takes a power-mode flag from the power sequencer. A falling edge on the sleep request puts the device to sleep, and a falling edge on the wake request brings it back. The level of the low-power select at the sleep edge picks between normal sleep and ultra-low-power sleep.

While asleep, the block asks the downstream converter to stay off by raising a power-good hold request. The isolation switch stays on. The block also produces two timed enables:
- an LED pulse enable with a 25% duty cycle;
- an internal load-current enable with a 75% duty cycle, which keeps the power signature valid.

In ultra-low-power sleep the load enable is further gated by a long burst pattern: on for a fixed window, then off for a longer window, repeating. All periods are given in clock cycles by parameters. A parameter chooses between a slow LED variant and a fast LED variant.

The controller is a three-state machine:
- `ST_AWAKE` is the normal running state.
- `ST_SLEEP` is normal sleep.
- `ST_ULP` is ultra-low-power sleep.

It has four transitions:
- ENTER_SLEEP goes from AWAKE to SLEEP on a sleep edge with the select high.
- ENTER_ULP goes from AWAKE to ULP on a sleep edge with the select low.
- WAKE goes from SLEEP or ULP to AWAKE on a wake edge.
- POWER_LOSS goes from SLEEP or ULP to AWAKE when the power-mode flag is low.

Top module: `slp_pulse_ctrl`

## Requirements
- R1: During and after reset, with all pins high, the state is AWAKE and all five outputs are 0.
- R2: A sleep-request fall seen while `pwr_ok_i`=1 and the low-power select is high enters SLEEP (ENTER_SLEEP). The outputs change at the third rising clock edge after the pin falls: `asleep_o`=1, `ulp_o`=0 and `pg_hold_o`=1.
- R3: A sleep-request fall seen while the low-power select is low (sampled with the same synchroniser delay) enters ULP (ENTER_ULP). The outputs then show `asleep_o`=1, `ulp_o`=1 and `pg_hold_o`=1.
- R4: A wake-request fall leaves SLEEP or ULP for AWAKE (WAKE) at the third rising edge after the pin falls. In AWAKE all outputs are 0.
- R5: While asleep, `led_pulse_o` is 1 for cycles n mod P < P/4, where n counts cycles from 0 at the first sleep cycle. P is `LED_SLOW_CYC` when `LED_FAST`=0 and `LED_FAST_CYC` when `LED_FAST`=1.
- R6: In SLEEP, `mps_load_o` is 1 for cycles n mod `LOAD_CYC` < 3*`LOAD_CYC`/4.
- R7: In ULP, `mps_load_o` follows the R6 pattern ANDed with a burst window that is 1 for n mod (`MPS_ON_CYC`+`MPS_OFF_CYC`) < `MPS_ON_CYC`.
- R8: A sleep-request fall while already asleep is ignored: the mode and the pulse phases continue unchanged.
- R9: If sleep and wake falls are seen in the same cycle, wake wins. From AWAKE the block stays awake, and from either sleep state it goes to AWAKE.
- R10: A sleep-request fall while `pwr_ok_i`=0 is ignored. When `pwr_ok_i` is 0 while asleep, the block is AWAKE after the next rising edge (POWER_LOSS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_req_n | input | 1 | Sleep request pin, falling edge enters sleep, idles high |
| wake_req_n | input | 1 | Wake request pin, falling edge leaves sleep, idles high |
| lowpwr_sel_n | input | 1 | Low selects ultra-low-power sleep at the sleep edge, idles high |
| pwr_ok_i | input | 1 | Power mode flag from the sequencer |
| asleep_o | output | 1 | 1 in SLEEP or ULP |
| ulp_o | output | 1 | 1 in ULP |
| led_pulse_o | output | 1 | LED current pulse enable |
| mps_load_o | output | 1 | Internal load current enable |
| pg_hold_o | output | 1 | Request to hold power-good low |

## Verification
The bench checks every cycle of long sleep windows against arithmetic models of the three counters. Two instances, one per LED variant, share the same stimulus, so one sweep checks both LED periods against the same load and burst phases. The tests cover:
- normal and ultra-low-power entry, which separates the gated load pattern from the plain one;
- repeated sleep edges inside sleep, which would expose a phase restart or a mode flip;
- coincident sleep and wake edges, both from awake and from asleep, which show the priority;
- sleep edges without power and power loss during sleep.

Wake latency is checked on both sides of the expected edge.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_SLEEP = 2'd1,
        ST_ULP   = 2'd2
    } slp_state_e;
endpackage

// File: rtl/slp_pin_sync.sv
module slp_pin_sync #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] meta_q, sync_q, hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
            hist_q <= '1;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign lvl_o  = sync_q;
    assign fall_o = hist_q & ~sync_q;
endmodule

// File: rtl/slp_duty.sv
module slp_duty #(
    parameter int unsigned PERIOD = 8,
    parameter int unsigned HIGH   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic on_o
);
    localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);
    localparam logic [W-1:0] EDGE = W'(HIGH);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign on_o = run_i && (cnt_q < EDGE);

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R5
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/slp_pulse_ctrl.sv
module slp_pulse_ctrl
    import slp_pkg::*;
#(
    parameter bit          LED_FAST     = 1'b0,
    parameter int unsigned LED_SLOW_CYC = 4000,
    parameter int unsigned LED_FAST_CYC = 64,
    parameter int unsigned LOAD_CYC     = 64,
    parameter int unsigned MPS_ON_CYC   = 84000,
    parameter int unsigned MPS_OFF_CYC  = 228000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slp_req_n,
    input  logic wake_req_n,
    input  logic lowpwr_sel_n,
    input  logic pwr_ok_i,
    output logic asleep_o,
    output logic ulp_o,
    output logic led_pulse_o,
    output logic mps_load_o,
    output logic pg_hold_o
);
    localparam int unsigned BURST_CYC = MPS_ON_CYC + MPS_OFF_CYC;
    localparam int unsigned LOAD_HI   = (3 * LOAD_CYC) / 4;

    logic [2:0] pin_lvl, pin_fall;
    logic       sl_fall, wk_fall, sel_lvl;
    slp_state_e state_q, state_d;
    logic       in_sleep, in_ulp, led_on, load_on, burst_on;

    slp_pin_sync #(.WIDTH(3)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({lowpwr_sel_n, wake_req_n, slp_req_n}),
        .lvl_o  (pin_lvl),
        .fall_o (pin_fall)
    );

    assign sl_fall = pin_fall[0];
    assign wk_fall = pin_fall[1];
    assign sel_lvl = pin_lvl[2];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE: begin
                if (pwr_ok_i && sl_fall && !wk_fall)
                    state_d = sel_lvl ? ST_SLEEP : ST_ULP;
            end
            ST_SLEEP, ST_ULP: begin
                if (!pwr_ok_i || wk_fall)
                    state_d = ST_AWAKE;
            end
            default: state_d = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_AWAKE;
        else
            state_q <= state_d;
    end

    assign in_sleep = (state_q == ST_SLEEP) || (state_q == ST_ULP);
    assign in_ulp   = (state_q == ST_ULP);

    generate
        if (LED_FAST) begin : g_led_fast
            slp_duty #(.PERIOD(LED_FAST_CYC), .HIGH(LED_FAST_CYC / 4)) led_i (
                .clk(clk), .rst_n(rst_n), .run_i(in_sleep), .on_o(led_on));
        end else begin : g_led_slow
            slp_duty #(.PERIOD(LED_SLOW_CYC), .HIGH(LED_SLOW_CYC / 4)) led_i (
                .clk(clk), .rst_n(rst_n), .run_i(in_sleep), .on_o(led_on));
        end
    endgenerate

    slp_duty #(.PERIOD(LOAD_CYC), .HIGH(LOAD_HI)) load_i (
        .clk(clk), .rst_n(rst_n), .run_i(in_sleep), .on_o(load_on));

    slp_duty #(.PERIOD(BURST_CYC), .HIGH(MPS_ON_CYC)) burst_i (
        .clk(clk), .rst_n(rst_n), .run_i(in_ulp), .on_o(burst_on));

    always_comb begin
        asleep_o    = 1'b0;
        ulp_o       = 1'b0;
        led_pulse_o = 1'b0;
        mps_load_o  = 1'b0;
        pg_hold_o   = 1'b0;
        unique case (state_q)
            ST_AWAKE: ;
            ST_SLEEP: begin
                asleep_o    = 1'b1;
                pg_hold_o   = 1'b1;
                led_pulse_o = led_on;
                mps_load_o  = load_on;
            end
            ST_ULP: begin
                asleep_o    = 1'b1;
                ulp_o       = 1'b1;
                pg_hold_o   = 1'b1;
                led_pulse_o = led_on;
                mps_load_o  = load_on && burst_on;
            end
            default: ;
        endcase
    end

    // R10
    pwr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok_i |=> !asleep_o);

    // R4
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wk_fall |=> !asleep_o);

    // R3
    ulp_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ulp_o |-> (asleep_o && pg_hold_o));

    // R5
    led_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        led_pulse_o |-> asleep_o);

    // R5
    first_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep_o) |-> led_pulse_o);

    // R7
    burst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ulp_o && !burst_on) |-> !mps_load_o);

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_o && $past(asleep_o)) |-> $stable(ulp_o));
endmodule

// File: tb/slp_pulse_ctrl_tb.sv
module slp_pulse_ctrl_tb_top;
    localparam time         CLK_P    = 10ns;
    localparam int unsigned LED_S    = 16;
    localparam int unsigned LED_F    = 8;
    localparam int unsigned LOAD     = 8;
    localparam int unsigned MON      = 24;
    localparam int unsigned MOFF     = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slp_n = 1'b1, wk_n = 1'b1, sel_n = 1'b1, pwr = 1'b1;
    logic asl, ulp, led_s, load, pg;
    logic asl_f, ulp_f, led_f, load_f, pg_f;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    slp_pulse_ctrl #(.LED_FAST(1'b0), .LED_SLOW_CYC(LED_S), .LED_FAST_CYC(LED_F),
        .LOAD_CYC(LOAD), .MPS_ON_CYC(MON), .MPS_OFF_CYC(MOFF)) dut_i (
        .clk(clk), .rst_n(rst_n), .slp_req_n(slp_n), .wake_req_n(wk_n),
        .lowpwr_sel_n(sel_n), .pwr_ok_i(pwr), .asleep_o(asl), .ulp_o(ulp),
        .led_pulse_o(led_s), .mps_load_o(load), .pg_hold_o(pg));

    slp_pulse_ctrl #(.LED_FAST(1'b1), .LED_SLOW_CYC(LED_S), .LED_FAST_CYC(LED_F),
        .LOAD_CYC(LOAD), .MPS_ON_CYC(MON), .MPS_OFF_CYC(MOFF)) dut_fast_i (
        .clk(clk), .rst_n(rst_n), .slp_req_n(slp_n), .wake_req_n(wk_n),
        .lowpwr_sel_n(sel_n), .pwr_ok_i(pwr), .asleep_o(asl_f), .ulp_o(ulp_f),
        .led_pulse_o(led_f), .mps_load_o(load_f), .pg_hold_o(pg_f));

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
        end
    endtask

    task automatic chk_awake(input string tag);
        chk(asl, 1'b0, {tag, " asleep"});
        chk(ulp, 1'b0, {tag, " ulp"});
        chk(led_s | led_f, 1'b0, {tag, " led"});
        chk(load | load_f, 1'b0, {tag, " load"});
        chk(pg | pg_f, 1'b0, {tag, " pg_hold"});
    endtask

    // Per-cycle model of the asleep outputs at sleep cycle n.
    task automatic sweep(input bit u, input int n0, input int cnt);
        for (int k = 0; k < cnt; k++) begin
            int n = n0 + k;
            logic ld;
            ld = ((n % LOAD) < (3 * LOAD) / 4) && (!u || ((n % (MON + MOFF)) < MON));
            chk(asl & asl_f, 1'b1, u ? "R3 asleep" : "R2 asleep");
            chk(pg, 1'b1, u ? "R3 pg_hold" : "R2 pg_hold");
            chk(ulp, u, u ? "R3 ulp" : "R2 ulp");
            chk(led_s, (n % LED_S) < LED_S / 4, "R5 led slow");
            chk(led_f, (n % LED_F) < LED_F / 4, "R5 led fast");
            chk(load, ld, u ? "R7 load ulp" : "R6 load sleep");
            chk(load_f, ld, u ? "R7 load ulp fast inst" : "R6 load sleep fast inst");
            @(negedge clk);
        end
    endtask

    task automatic idle(input int cnt, input string tag);
        for (int k = 0; k < cnt; k++) begin
            chk_awake(tag);
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_awake("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle(5, "R1 after reset");

        // R2 normal sleep entry
        slp_n = 1'b0;
        repeat (3) @(negedge clk);
        slp_n = 1'b1;
        sweep(1'b0, 0, 80);

        // R8 second sleep edge with select low while asleep
        slp_n = 1'b0; sel_n = 1'b0;
        sweep(1'b0, 80, 40);
        slp_n = 1'b1; sel_n = 1'b1;
        sweep(1'b0, 120, 4);

        // R4 wake from sleep, latency on both sides
        wk_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(asl, 1'b1, "R4 before wake edge");
        @(negedge clk);
        wk_n = 1'b1;
        idle(5, "R4 wake from sleep");

        // R3 / R7 ultra-low-power entry
        slp_n = 1'b0; sel_n = 1'b0;
        repeat (3) @(negedge clk);
        slp_n = 1'b1; sel_n = 1'b1;
        sweep(1'b1, 0, 140);

        // R4 wake from ULP
        wk_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(ulp, 1'b1, "R4 before wake edge ulp");
        @(negedge clk);
        wk_n = 1'b1;
        idle(5, "R4 wake from ulp");

        // R9 coincident edges while awake
        slp_n = 1'b0; wk_n = 1'b0;
        repeat (3) @(negedge clk);
        idle(6, "R9 coincident awake");
        slp_n = 1'b1; wk_n = 1'b1;
        idle(4, "R9 release");

        // R9 coincident edges while asleep
        slp_n = 1'b0;
        repeat (3) @(negedge clk);
        slp_n = 1'b1;
        sweep(1'b0, 0, 10);
        slp_n = 1'b0; wk_n = 1'b0;
        repeat (3) @(negedge clk);
        slp_n = 1'b1; wk_n = 1'b1;
        idle(5, "R9 coincident asleep");

        // R10 sleep edge without power
        pwr = 1'b0;
        @(negedge clk);
        slp_n = 1'b0;
        repeat (3) @(negedge clk);
        idle(6, "R10 no power");
        slp_n = 1'b1;
        pwr = 1'b1;
        idle(4, "R10 power back");

        // R10 power loss while asleep
        slp_n = 1'b0;
        repeat (3) @(negedge clk);
        slp_n = 1'b1;
        sweep(1'b0, 0, 5);
        pwr = 1'b0;
        @(negedge clk);
        idle(3, "R10 power loss");
        pwr = 1'b1;
        idle(3, "R10 power restored");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule